// File: doc/BRIEF.md
# SMM interrupt gating controller

This block holds the interrupt and trap gating that a processor core applies while it enters, runs in, and leaves system management mode. An entry pulse switches it into the mode. Entry clears the maskable-interrupt enable, the single-step trap flag and the debug-trap enable, and it blocks non-maskable interrupts. A resume pulse leaves the mode. The handler can turn the flags back on through flag writes. An IRET pulse inside the mode lifts the NMI block early.

An NMI rising edge that arrives while the block is in force is held in a pending bit. That bit stores one request and no more. The request is delivered at the first instruction boundary once the block is gone. The block tells the core which event to take through one-cycle strobes: NMI, maskable interrupt, single-step trap and debug trap, each timed from an instruction-boundary or debug-hit input. Software-interrupt requests pass straight through whatever the mode. A 32-bit revision word is driven as a constant.

Top module: `smm_irq_gate`

## Requirements
- R1: One cycle after an entry pulse given outside the mode, `smm_active_o` is 1 and `if_o`, `tf_o` and `dbg_en_o` are all 0. The entry clear wins over a flag write in the same cycle.
- R2: From entry until an IRET or a resume, no `nmi_take_o` strobe occurs. The first NMI rising edge in that interval sets a pending bit of depth one. Any further edges while the bit is set are lost.
- R3: A resume pulse inside the mode makes `smm_active_o` 0 on the next cycle and removes the NMI block. A pending NMI then gives exactly one `nmi_take_o`, in the cycle after the first `boundary_i` that follows the exit.
- R4: An IRET pulse inside the mode removes the NMI block while `smm_active_o` stays 1. A pending NMI, or a later one, is then strobed in the cycle after a boundary.
- R5: `intr_take_o` pulses in the cycle after `boundary_i` with `intr_i` high, but only if `if_o` was 1. `step_trap_o` pulses in the cycle after `boundary_i`, but only if `tf_o` was 1. `dbg_trap_o` pulses in the cycle after `dbg_hit_i`, but only if `dbg_en_o` was 1. Flag writes (`wr_*_i` with value `*_val_i`) take effect on the next cycle, inside or outside the mode.
- R6: `swi_take_o` equals `swi_req_i` delayed by one cycle, in every mode.
- R7: `rev_id_o` is 32'h0003_0000 at all times: bit 17 = 1, bit 16 = 1, all other bits 0.
- R8: NMI is edge-sensitive. A line held high counts as a single request.
- R9: Outside the mode with no block, a pending NMI is strobed in the cycle after the next boundary. When the NMI and a maskable interrupt are both eligible at the same boundary, only `nmi_take_o` pulses.
- R10: An entry pulse while already in the mode has no effect, so flags written inside the mode keep their values. A resume pulse outside the mode has no effect.
- R11: Synchronous reset clears the mode, the pending bit, the NMI block, all flags and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smm_enter_i | input | 1 | Enter-mode pulse |
| rsm_i | input | 1 | Resume (leave-mode) pulse |
| iret_i | input | 1 | IRET executed pulse |
| nmi_i | input | 1 | NMI request line (edge-sensitive) |
| intr_i | input | 1 | Maskable interrupt request level |
| boundary_i | input | 1 | Instruction boundary reached |
| dbg_hit_i | input | 1 | Debug breakpoint match |
| swi_req_i | input | 1 | Software interrupt request |
| wr_if_i | input | 1 | Write strobe for interrupt-enable flag |
| if_val_i | input | 1 | Value for interrupt-enable flag |
| wr_tf_i | input | 1 | Write strobe for trap flag |
| tf_val_i | input | 1 | Value for trap flag |
| wr_dbg_i | input | 1 | Write strobe for debug-trap enable |
| dbg_val_i | input | 1 | Value for debug-trap enable |
| smm_active_o | output | 1 | Mode is active |
| if_o | output | 1 | Interrupt-enable flag |
| tf_o | output | 1 | Single-step trap flag |
| dbg_en_o | output | 1 | Debug-trap enable |
| nmi_take_o | output | 1 | Take-NMI strobe |
| intr_take_o | output | 1 | Take-maskable-interrupt strobe |
| step_trap_o | output | 1 | Take-single-step strobe |
| dbg_trap_o | output | 1 | Take-debug-trap strobe |
| swi_take_o | output | 1 | Software interrupt forwarded |
| rev_id_o | output | 32 | Constant revision word |

## Verification
The bench builds the block with its default parameters. These are a 32-bit identifier word and a 16-bit revision level of zero, so the constant 32'h0003_0000 can be checked directly. Because the gating has no width parameter, these defaults reach every path. The sequences cover the following cases:
- a double NMI inside the mode, followed by a resume, with the take counter checked;
- an early unblock by IRET;
- NMI and maskable interrupt eligible at the same boundary;
- a repeated entry and an out-of-mode resume;
- a held-high NMI line.

// File: rtl/smm_gate_pkg.sv
package smm_gate_pkg;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_SMM    = 1'b1
  } smm_mode_e;

  localparam int unsigned FLAG_N   = 3;
  localparam int unsigned FLAG_IEN = 0;
  localparam int unsigned FLAG_TRP = 1;
  localparam int unsigned FLAG_DBG = 2;

  localparam int unsigned RELOC_BIT  = 17;
  localparam int unsigned IOTRAP_BIT = 16;

endpackage

// File: rtl/smm_mode_fsm.sv
module smm_mode_fsm
  import smm_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enter_i,
  input  logic rsm_i,
  output logic active_o,
  output logic enter_o,
  output logic exit_o
);

  smm_mode_e mode_q;

  assign enter_o  = enter_i && (mode_q == MODE_NORMAL);
  assign exit_o   = rsm_i && (mode_q == MODE_SMM);
  assign active_o = (mode_q == MODE_SMM);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_NORMAL;
    end else if (enter_o) begin
      mode_q <= MODE_SMM;
    end else if (exit_o) begin
      mode_q <= MODE_NORMAL;
    end
  end

endmodule

// File: rtl/smm_nmi_latch.sv
module smm_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_i,
  input  logic enter_i,
  input  logic exit_i,
  input  logic iret_i,
  input  logic active_i,
  input  logic take_i,
  output logic ready_o,
  output logic blocked_o
);

  logic nmi_prev_q;
  logic pend_q;
  logic blk_q;
  logic rise;

  assign rise      = nmi_i && !nmi_prev_q;
  assign ready_o   = pend_q && !blk_q;
  assign blocked_o = blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev_q <= 1'b0;
      pend_q     <= 1'b0;
      blk_q      <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_i;
      pend_q     <= (pend_q && !take_i) || rise;
      if (enter_i) begin
        blk_q <= 1'b1;
      end else if (exit_i) begin
        blk_q <= 1'b0;
      end else if (iret_i && active_i) begin
        blk_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/smm_flag_regs.sv
module smm_flag_regs
  import smm_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic [FLAG_N-1:0] wr_i,
  input  logic [FLAG_N-1:0] val_i,
  output logic [FLAG_N-1:0] flags_o
);

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        bit_q <= 1'b0;
      end else if (wr_i[g]) begin
        bit_q <= val_i[g];
      end
    end
    assign flags_o[g] = bit_q;
  end

endmodule

// File: rtl/smm_take_arb.sv
module smm_take_arb
  import smm_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic              nmi_ready_i,
  input  logic              intr_i,
  input  logic              dbg_hit_i,
  input  logic              swi_i,
  input  logic [FLAG_N-1:0] flags_i,
  output logic              nmi_fire_o,
  output logic              nmi_take_o,
  output logic              intr_take_o,
  output logic              step_o,
  output logic              dbg_trap_o,
  output logic              swi_o
);

  logic intr_fire;

  assign nmi_fire_o = boundary_i && nmi_ready_i;
  assign intr_fire  = boundary_i && intr_i && flags_i[FLAG_IEN] && !nmi_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_take_o  <= 1'b0;
      intr_take_o <= 1'b0;
      step_o      <= 1'b0;
      dbg_trap_o  <= 1'b0;
      swi_o       <= 1'b0;
    end else begin
      nmi_take_o  <= nmi_fire_o;
      intr_take_o <= intr_fire;
      step_o      <= boundary_i && flags_i[FLAG_TRP];
      dbg_trap_o  <= dbg_hit_i && flags_i[FLAG_DBG];
      swi_o       <= swi_i;
    end
  end

endmodule

// File: rtl/smm_irq_gate.sv
module smm_irq_gate
  import smm_gate_pkg::*;
#(
  parameter int unsigned ID_W      = 32,
  parameter int unsigned LEVEL_W   = 16,
  parameter int unsigned REV_LEVEL = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smm_enter_i,
  input  logic            rsm_i,
  input  logic            iret_i,
  input  logic            nmi_i,
  input  logic            intr_i,
  input  logic            boundary_i,
  input  logic            dbg_hit_i,
  input  logic            swi_req_i,
  input  logic            wr_if_i,
  input  logic            if_val_i,
  input  logic            wr_tf_i,
  input  logic            tf_val_i,
  input  logic            wr_dbg_i,
  input  logic            dbg_val_i,
  output logic            smm_active_o,
  output logic            if_o,
  output logic            tf_o,
  output logic            dbg_en_o,
  output logic            nmi_take_o,
  output logic            intr_take_o,
  output logic            step_trap_o,
  output logic            dbg_trap_o,
  output logic            swi_take_o,
  output logic [ID_W-1:0] rev_id_o
);

  localparam logic [LEVEL_W-1:0] LEVEL_FIELD = LEVEL_W'(REV_LEVEL);
  localparam logic [ID_W-1:0] REV_WORD =
      (ID_W'(1) << RELOC_BIT) | (ID_W'(1) << IOTRAP_BIT) | ID_W'(LEVEL_FIELD);

  logic              enter_act;
  logic              exit_act;
  logic              nmi_ready;
  logic              nmi_blocked;
  logic              nmi_fire;
  logic [FLAG_N-1:0] flag_wr;
  logic [FLAG_N-1:0] flag_val;
  logic [FLAG_N-1:0] flags;

  assign flag_wr  = {wr_dbg_i, wr_tf_i, wr_if_i};
  assign flag_val = {dbg_val_i, tf_val_i, if_val_i};

  smm_mode_fsm u_mode (
    .clk      (clk),
    .rst      (rst),
    .enter_i  (smm_enter_i),
    .rsm_i    (rsm_i),
    .active_o (smm_active_o),
    .enter_o  (enter_act),
    .exit_o   (exit_act)
  );

  smm_nmi_latch u_nmi (
    .clk       (clk),
    .rst       (rst),
    .nmi_i     (nmi_i),
    .enter_i   (enter_act),
    .exit_i    (exit_act),
    .iret_i    (iret_i),
    .active_i  (smm_active_o),
    .take_i    (nmi_fire),
    .ready_o   (nmi_ready),
    .blocked_o (nmi_blocked)
  );

  smm_flag_regs u_flags (
    .clk     (clk),
    .rst     (rst),
    .clear_i (enter_act),
    .wr_i    (flag_wr),
    .val_i   (flag_val),
    .flags_o (flags)
  );

  smm_take_arb u_arb (
    .clk         (clk),
    .rst         (rst),
    .boundary_i  (boundary_i),
    .nmi_ready_i (nmi_ready),
    .intr_i      (intr_i),
    .dbg_hit_i   (dbg_hit_i),
    .swi_i       (swi_req_i),
    .flags_i     (flags),
    .nmi_fire_o  (nmi_fire),
    .nmi_take_o  (nmi_take_o),
    .intr_take_o (intr_take_o),
    .step_o      (step_trap_o),
    .dbg_trap_o  (dbg_trap_o),
    .swi_o       (swi_take_o)
  );

  assign if_o     = flags[FLAG_IEN];
  assign tf_o     = flags[FLAG_TRP];
  assign dbg_en_o = flags[FLAG_DBG];
  assign rev_id_o = REV_WORD;

endmodule

// File: rtl/smm_irq_gate_chk.sv
module smm_irq_gate_chk (
  input logic clk,
  input logic rst,
  input logic smm_enter_i,
  input logic rsm_i,
  input logic smm_active_o,
  input logic if_o,
  input logic tf_o,
  input logic dbg_en_o,
  input logic nmi_take_o,
  input logic intr_take_o,
  input logic step_trap_o,
  input logic dbg_trap_o,
  input logic nmi_blocked
);

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(smm_active_o) |-> (!if_o && !tf_o && !dbg_en_o)); // R1
  AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(smm_active_o) |-> $past(smm_enter_i)); // R1
  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(smm_active_o) |-> $past(rsm_i)); // R3
  AST_NMI_UNBLOCKED: assert property (@(posedge clk) disable iff (rst)
    nmi_take_o |-> !$past(nmi_blocked)); // R2
  AST_BLOCK_IN_MODE: assert property (@(posedge clk) disable iff (rst)
    nmi_blocked |-> smm_active_o); // R4
  AST_INTR_NEEDS_IF: assert property (@(posedge clk) disable iff (rst)
    intr_take_o |-> $past(if_o)); // R5
  AST_STEP_NEEDS_TF: assert property (@(posedge clk) disable iff (rst)
    step_trap_o |-> $past(tf_o)); // R5
  AST_DBG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    dbg_trap_o |-> $past(dbg_en_o)); // R5
  AST_NMI_OVER_INTR: assert property (@(posedge clk) disable iff (rst)
    !(nmi_take_o && intr_take_o)); // R9

endmodule

bind smm_irq_gate smm_irq_gate_chk u_chk (.*);

// File: tb/smm_irq_gate_tb.sv
module smm_irq_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smm_enter_i = 0, rsm_i = 0, iret_i = 0, nmi_i = 0, intr_i = 0;
  logic boundary_i = 0, dbg_hit_i = 0, swi_req_i = 0;
  logic wr_if_i = 0, if_val_i = 0, wr_tf_i = 0, tf_val_i = 0;
  logic wr_dbg_i = 0, dbg_val_i = 0;
  logic smm_active_o, if_o, tf_o, dbg_en_o, nmi_take_o, intr_take_o;
  logic step_trap_o, dbg_trap_o, swi_take_o;
  logic [31:0] rev_id_o;

  int vectors = 0;
  int errors = 0;
  int nmi_cnt = 0;
  bit done = 0;

  // behavioural reference state
  bit m_prev, m_pend, m_blk, m_smm, m_if, m_tf, m_dbg;
  bit m_nt, m_it, m_st, m_dt, m_sw;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_irq_gate dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_prev, m_pend, m_blk, m_smm, m_if, m_tf, m_dbg} = '0;
    {m_nt, m_it, m_st, m_dt, m_sw} = '0;
  endtask

  task automatic model_step();
    bit rise, en, ex, ok_nmi;
    bit n_nt, n_it, n_st, n_dt, n_sw, n_pend, n_blk, n_smm, n_if, n_tf, n_dbg;
    rise = nmi_i && !m_prev;
    en = smm_enter_i && !m_smm;
    ex = rsm_i && m_smm;
    ok_nmi = m_pend && !m_blk;
    n_nt = boundary_i && ok_nmi;
    n_it = boundary_i && intr_i && m_if && !ok_nmi;
    n_st = boundary_i && m_tf;
    n_dt = dbg_hit_i && m_dbg;
    n_sw = swi_req_i;
    n_pend = (m_pend && !n_nt) || rise;
    n_blk = m_blk;
    if (en) n_blk = 1; else if (ex) n_blk = 0; else if (iret_i && m_smm) n_blk = 0;
    n_smm = en ? 1'b1 : (ex ? 1'b0 : m_smm);
    n_if = m_if; n_tf = m_tf; n_dbg = m_dbg;
    if (en) begin
      n_if = 0; n_tf = 0; n_dbg = 0;
    end else begin
      if (wr_if_i) n_if = if_val_i;
      if (wr_tf_i) n_tf = tf_val_i;
      if (wr_dbg_i) n_dbg = dbg_val_i;
    end
    m_prev = nmi_i; m_pend = n_pend; m_blk = n_blk; m_smm = n_smm;
    m_if = n_if; m_tf = n_tf; m_dbg = n_dbg;
    m_nt = n_nt; m_it = n_it; m_st = n_st; m_dt = n_dt; m_sw = n_sw;
  endtask

  task automatic compare();
    chk(smm_active_o == m_smm, "R1 smm_active_o", smm_active_o, m_smm);
    chk(if_o == m_if, "R5 if_o", if_o, m_if);
    chk(tf_o == m_tf, "R5 tf_o", tf_o, m_tf);
    chk(dbg_en_o == m_dbg, "R5 dbg_en_o", dbg_en_o, m_dbg);
    chk(nmi_take_o == m_nt, "R3 nmi_take_o", nmi_take_o, m_nt);
    chk(intr_take_o == m_it, "R9 intr_take_o", intr_take_o, m_it);
    chk(step_trap_o == m_st, "R5 step_trap_o", step_trap_o, m_st);
    chk(dbg_trap_o == m_dt, "R5 dbg_trap_o", dbg_trap_o, m_dt);
    chk(swi_take_o == m_sw, "R6 swi_take_o", swi_take_o, m_sw);
    chk(rev_id_o == 32'h0003_0000, "R7 rev_id_o", rev_id_o, 32'h0003_0000);
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    compare();
    if (nmi_take_o) nmi_cnt++;
  endtask

  task automatic idle();
    {smm_enter_i, rsm_i, iret_i, intr_i, boundary_i, dbg_hit_i, swi_req_i} = '0;
    {wr_if_i, wr_tf_i, wr_dbg_i} = '0;
  endtask

  initial begin
    repeat (3) step();
    chk(!smm_active_o && !if_o && !tf_o && !dbg_en_o && !nmi_take_o,
        "R11 reset state", {smm_active_o, if_o, tf_o, dbg_en_o, nmi_take_o}, 0);
    rst = 0;
    step();

    // R5 / R9: interrupt outside the mode
    wr_if_i = 1; if_val_i = 1; step(); wr_if_i = 0;
    intr_i = 1; boundary_i = 1; step();
    chk(intr_take_o == 1, "R9 intr taken outside", intr_take_o, 1);
    idle();
    // R8 / R9: held NMI and priority
    nmi_i = 1; step();
    intr_i = 1; boundary_i = 1; step();
    chk(nmi_take_o && !intr_take_o, "R9 nmi wins", {nmi_take_o, intr_take_o}, 2'b10);
    step();
    chk(!nmi_take_o && intr_take_o, "R8 held nmi counted once", {nmi_take_o, intr_take_o}, 2'b01);
    idle(); nmi_i = 0; step();

    // R1: entry clears flags, beats a write in the same cycle
    wr_tf_i = 1; tf_val_i = 1; wr_dbg_i = 1; dbg_val_i = 1; step();
    smm_enter_i = 1; wr_if_i = 1; if_val_i = 1; step(); idle();
    chk(smm_active_o && !if_o && !tf_o && !dbg_en_o, "R1 entry clears",
        {smm_active_o, if_o, tf_o, dbg_en_o}, 4'b1000);
    boundary_i = 1; dbg_hit_i = 1; intr_i = 1; step(); idle();
    chk(!step_trap_o && !dbg_trap_o && !intr_take_o, "R5 gated in mode",
        {step_trap_o, dbg_trap_o, intr_take_o}, 0);

    // R10: repeated entry ignored
    wr_tf_i = 1; tf_val_i = 1; step(); wr_tf_i = 0;
    smm_enter_i = 1; step(); idle();
    chk(tf_o == 1, "R10 second entry ignored", tf_o, 1);
    boundary_i = 1; step(); idle();
    chk(step_trap_o == 1, "R5 step trap re-enabled", step_trap_o, 1);
    wr_tf_i = 1; tf_val_i = 0; step(); idle();

    // R6: software interrupt passes in the mode
    swi_req_i = 1; step(); idle();
    chk(swi_take_o == 1, "R6 swi in mode", swi_take_o, 1);

    // R2: two edges blocked and latched once
    nmi_cnt = 0;
    boundary_i = 1;
    nmi_i = 1; step(); nmi_i = 0; step(); nmi_i = 1; step(); nmi_i = 0; step();
    chk(nmi_cnt == 0, "R2 nmi blocked in mode", nmi_cnt, 0);
    rsm_i = 1; step(); rsm_i = 0;
    chk(!smm_active_o, "R3 resume exits", smm_active_o, 0);
    repeat (4) step();
    chk(nmi_cnt == 1, "R3 one nmi after resume (R2 depth)", nmi_cnt, 1);
    idle();

    // R10: resume outside ignored
    wr_if_i = 1; if_val_i = 1; step(); wr_if_i = 0;
    rsm_i = 1; step(); idle();
    chk(!smm_active_o && if_o, "R10 resume outside ignored", {smm_active_o, if_o}, 2'b01);

    // R4: IRET unblocks inside the mode
    smm_enter_i = 1; step(); idle();
    nmi_cnt = 0;
    nmi_i = 1; step(); nmi_i = 0; boundary_i = 1; step();
    chk(nmi_cnt == 0, "R4 blocked before iret", nmi_cnt, 0);
    boundary_i = 0; iret_i = 1; step(); iret_i = 0; boundary_i = 1; step(); idle();
    chk(nmi_take_o && smm_active_o, "R4 nmi taken after iret", {nmi_take_o, smm_active_o}, 2'b11);
    nmi_i = 1; step(); nmi_i = 0; boundary_i = 1; step(); idle();
    chk(nmi_take_o == 1, "R4 later nmi taken in mode", nmi_take_o, 1);

    // R5: interrupt enable in mode
    wr_if_i = 1; if_val_i = 1; wr_dbg_i = 1; dbg_val_i = 1; step(); idle();
    intr_i = 1; boundary_i = 1; dbg_hit_i = 1; step(); idle();
    chk(intr_take_o && dbg_trap_o, "R5 intr and dbg in mode", {intr_take_o, dbg_trap_o}, 2'b11);
    rsm_i = 1; step(); idle();
    repeat (3) step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule